// File: doc/BRIEF.md
# Step Condition Decoder

This block decides, for one step of a programmable trigger sequencer, which of a small set of numbered conditions currently holds. Each condition owns a decode register. That register chooses which of the observed terms take part, and which level each of them must show. The terms are the AND-summary and OR-summary bits of four signal-priority groups, plus the outputs of a timer comparator and a counter comparator. A final bit can invert the decoded result.

All true conditions are reported as a bit vector. The lowest-numbered true condition wins, and its index is reported. When nothing is true, a no-match flag tells the surrounding sequencer to apply the step's default action. Software loads the decode registers through a single-cycle write port. The result paths from the registers and the term inputs to the outputs are combinational.

Top module: `cond_decode_unit`

## Requirements
- R1: After reset every decode register holds zero, so all conditions read false and `none_hit` is 1 whatever the term inputs are.
- R2: For group g, bit 4g+1 includes the group's AND bit and bit 4g gives its required level (1 = must be 1, 0 = must be 0). A value of 0x3 in a condition makes it true exactly when group 0's AND bit is 1, and 0x30 does the same for group 1.
- R3: For group g, bit 4g+3 includes the group's OR bit and bit 4g+2 gives its required level.
- R4: Bit 17 includes the timer comparator bit and bit 16 gives its required level. A value of 0x30000 means the timer comparator must be 1.
- R5: Bit 21 includes the counter comparator bit and bit 20 gives its required level.
- R6: A condition that includes several terms is true only when every included term shows its required level. A level bit whose include bit is clear has no effect.
- R7: A condition that includes no term decodes false. Bit 24 then inverts the decoded result, so a register holding only bit 24 reads true.
- R8: `win_idx` is the lowest index among the true conditions, so condition 0 beats condition 1.
- R9: `none_hit` is 1 exactly when no condition is true, and `win_idx` is 0 in that case.
- R10: A write with `wr_en` high and `wr_idx` below NUM_COND loads `wr_data` into that condition's register at the clock edge. A write with `wr_idx` at or above NUM_COND changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for a decode register |
| wr_idx | input | $clog2(NUM_COND)+1 | Condition index to write |
| wr_data | input | 25 | Decode register value |
| grp_and | input | 4 | AND-summary bit of each priority group |
| grp_or | input | 4 | OR-summary bit of each priority group |
| tmr_cmp | input | 1 | Timer comparator output |
| cnt_cmp | input | 1 | Counter comparator output |
| cond_hit | output | NUM_COND | One bit per condition that is currently true |
| win_idx | output | $clog2(NUM_COND) | Index of the winning condition |
| none_hit | output | 1 | No condition is true |

## Verification
On every cycle, the assertions check three things. The reported winner is a true condition with no true condition below it. The no-match flag agrees with the hit vector and forces index 0. The registers hold when a write is absent or out of range. They also check that a register with no included term and no inversion never reads true.

The term semantics cannot be seen by the assertions. That covers the field positions, the polarity selection, the AND across terms and the inversion, as well as the reset value of the registers. Only the bench shows them, by comparing its scenarios against an independent model of the field encoding.

// File: rtl/cdec_pkg.sv
package cdec_pkg;
  localparam int unsigned NGRP  = 4;
  localparam int unsigned DEC_W = 25;
  localparam int unsigned NTERM = 2 * NGRP + 2;
  localparam int unsigned TMR_ACT = 17;
  localparam int unsigned TMR_POL = 16;
  localparam int unsigned CNT_ACT = 21;
  localparam int unsigned CNT_POL = 20;
  localparam int unsigned INV_BIT = 24;
endpackage

// File: rtl/cdec_rst_sync.sv
module cdec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/cdec_regfile.sv
module cdec_regfile
  import cdec_pkg::*;
#(
  parameter int unsigned NUM_COND = 4,
  localparam int unsigned IDX_W = $clog2(NUM_COND) + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [DEC_W-1:0]                wr_data,
  output logic [NUM_COND-1:0][DEC_W-1:0]  dec_q
);
  logic [NUM_COND-1:0][DEC_W-1:0] dec_d;
  logic [NUM_COND-1:0]            load;

  always_comb begin
    for (int c = 0; c < NUM_COND; c++) begin
      load[c]  = wr_en && (wr_idx == IDX_W'(c));
      dec_d[c] = wr_data;
    end
  end

  for (genvar c = 0; c < NUM_COND; c++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dec_q[c] <= '0;
      else if (load[c]) dec_q[c] <= dec_d[c];
    end
  end
endmodule

// File: rtl/cdec_cond_eval.sv
module cdec_cond_eval
  import cdec_pkg::*;
(
  input  logic [DEC_W-1:0] dec,
  input  logic [NGRP-1:0]  grp_and,
  input  logic [NGRP-1:0]  grp_or,
  input  logic             tmr_cmp,
  input  logic             cnt_cmp,
  output logic             hit
);
  logic [NTERM-1:0] act, lvl, val, ok;
  logic             raw;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign act[2*g]   = dec[4*g+1];
    assign lvl[2*g]   = dec[4*g];
    assign val[2*g]   = grp_and[g];
    assign act[2*g+1] = dec[4*g+3];
    assign lvl[2*g+1] = dec[4*g+2];
    assign val[2*g+1] = grp_or[g];
  end

  assign act[2*NGRP]   = dec[TMR_ACT];
  assign lvl[2*NGRP]   = dec[TMR_POL];
  assign val[2*NGRP]   = tmr_cmp;
  assign act[2*NGRP+1] = dec[CNT_ACT];
  assign lvl[2*NGRP+1] = dec[CNT_POL];
  assign val[2*NGRP+1] = cnt_cmp;

  assign ok  = ~act | ~(val ^ lvl);
  assign raw = (|act) & (&ok);
  assign hit = raw ^ dec[INV_BIT];

  logic unused_ok;
  assign unused_ok = ^{dec[23:22], dec[19:18]};
endmodule

// File: rtl/cdec_prio_pick.sv
module cdec_prio_pick #(
  parameter int unsigned NUM_COND = 4,
  localparam int unsigned SEL_W = $clog2(NUM_COND)
) (
  input  logic [NUM_COND-1:0] hit,
  output logic [SEL_W-1:0]    win,
  output logic                none
);
  always_comb begin
    win  = '0;
    none = 1'b1;
    for (int c = NUM_COND - 1; c >= 0; c--) begin
      if (hit[c]) begin
        win  = SEL_W'(c);
        none = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cond_decode_unit.sv
module cond_decode_unit
  import cdec_pkg::*;
#(
  parameter int unsigned NUM_COND = 4,
  localparam int unsigned IDX_W = $clog2(NUM_COND) + 1,
  localparam int unsigned SEL_W = $clog2(NUM_COND)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DEC_W-1:0]    wr_data,
  input  logic [NGRP-1:0]     grp_and,
  input  logic [NGRP-1:0]     grp_or,
  input  logic                tmr_cmp,
  input  logic                cnt_cmp,
  output logic [NUM_COND-1:0] cond_hit,
  output logic [SEL_W-1:0]    win_idx,
  output logic                none_hit
);
  logic                           rst_n_sync;
  logic [NUM_COND-1:0][DEC_W-1:0] dec_q;

  cdec_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cdec_regfile #(.NUM_COND(NUM_COND)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .dec_q   (dec_q)
  );

  for (genvar c = 0; c < NUM_COND; c++) begin : g_cond
    cdec_cond_eval u_eval (
      .dec     (dec_q[c]),
      .grp_and (grp_and),
      .grp_or  (grp_or),
      .tmr_cmp (tmr_cmp),
      .cnt_cmp (cnt_cmp),
      .hit     (cond_hit[c])
    );
  end

  cdec_prio_pick #(.NUM_COND(NUM_COND)) u_pick (
    .hit  (cond_hit),
    .win  (win_idx),
    .none (none_hit)
  );
endmodule

// File: rtl/cdec_checker.sv
module cdec_checker
  import cdec_pkg::*;
#(
  parameter int unsigned NUM_COND = 4,
  localparam int unsigned IDX_W = $clog2(NUM_COND) + 1,
  localparam int unsigned SEL_W = $clog2(NUM_COND)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic [IDX_W-1:0]               wr_idx,
  input logic [NUM_COND-1:0][DEC_W-1:0] dec_q,
  input logic [NUM_COND-1:0]            cond_hit,
  input logic [SEL_W-1:0]               win_idx,
  input logic                           none_hit
);
  logic [NUM_COND-1:0] below_mask;
  assign below_mask = (NUM_COND'(1) << win_idx) - NUM_COND'(1);

  p_winner_true_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !none_hit |-> cond_hit[win_idx]);

  p_none_below_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !none_hit |-> ((cond_hit & below_mask) == '0));

  p_nomatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    none_hit |-> (cond_hit == '0) && (win_idx == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dec_q));

  p_oob_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= IDX_W'(NUM_COND))) |=> $stable(dec_q));

  for (genvar c = 0; c < NUM_COND; c++) begin : g_empty
    p_empty_false_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((dec_q[c] & 25'h1_22_AAAA) == '0) |-> !cond_hit[c]);
  end
endmodule

bind cond_decode_unit cdec_checker #(.NUM_COND(NUM_COND)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .dec_q    (dec_q),
  .cond_hit (cond_hit),
  .win_idx  (win_idx),
  .none_hit (none_hit)
);

// File: tb/tb_cond_decode_unit.sv
module tb_cond_decode_unit;
  localparam int NC = 4;
  localparam int IW = $clog2(NC) + 1;
  localparam int SW = $clog2(NC);

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [24:0]   wr_data;
  logic [3:0]    grp_and, grp_or;
  logic          tmr_cmp, cnt_cmp;
  logic [NC-1:0] cond_hit;
  logic [SW-1:0] win_idx;
  logic          none_hit;

  int total = 0;
  int bad   = 0;
  logic [24:0] mdl [NC];

  cond_decode_unit #(.NUM_COND(NC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .grp_and(grp_and), .grp_or(grp_or), .tmr_cmp(tmr_cmp), .cnt_cmp(cnt_cmp),
    .cond_hit(cond_hit), .win_idx(win_idx), .none_hit(none_hit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Model of the field encoding: a term is (include bit, level bit, observed value).
  function automatic logic term_ok(logic [24:0] r, int a, int l, logic v);
    return !r[a] || (r[l] == v);
  endfunction

  function automatic logic model_hit(logic [24:0] r);
    logic any, all;
    any = r[17] | r[21];
    all = term_ok(r, 17, 16, tmr_cmp) && term_ok(r, 21, 20, cnt_cmp);
    for (int g = 0; g < 4; g++) begin
      any = any | r[4*g+1] | r[4*g+3];
      all = all && term_ok(r, 4*g+1, 4*g, grp_and[g]) && term_ok(r, 4*g+3, 4*g+2, grp_or[g]);
    end
    return (any && all) ^ r[24];
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic check_model(string tag);
    logic [NC-1:0] eh;
    int ew;
    eh = '0;
    ew = 0;
    for (int c = NC - 1; c >= 0; c--) begin
      eh[c] = model_hit(mdl[c]);
      if (eh[c]) ew = c;
    end
    check({tag, " hit"}, 32'(cond_hit), 32'(eh));
    check({tag, " win"}, 32'(win_idx), 32'(ew));
    check({tag, " none"}, 32'(none_hit), 32'(eh == '0));
  endtask

  task automatic wr(int idx, logic [24:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < NC) mdl[idx] = d;
  endtask

  task automatic drive(logic [3:0] a, logic [3:0] o, logic t, logic k);
    @(negedge clk);
    grp_and = a; grp_or = o; tmr_cmp = t; cnt_cmp = k;
    #2;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    grp_and = 4'hF; grp_or = 4'hF; tmr_cmp = 1'b1; cnt_cmp = 1'b1;
    for (int c = 0; c < NC; c++) mdl[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    // R1: reset contents read as all-false
    check("R1 hit", 32'(cond_hit), 0);
    check("R1 none", 32'(none_hit), 1);

    // R2: 0x3 on cond 0, 0x30 on cond 1
    wr(0, 25'h3);
    wr(1, 25'h30);
    drive(4'b0001, 4'h0, 0, 0);
    check("R2 grp0 and", 32'(cond_hit), 32'b0001);
    drive(4'b0010, 4'h0, 0, 0);
    check("R2 grp1 and", 32'(cond_hit), 32'b0010);
    check("R2 win", 32'(win_idx), 1);
    // R8: both true -> 0 wins
    drive(4'b0011, 4'h0, 0, 0);
    check("R8 both", 32'(cond_hit), 32'b0011);
    check("R8 win", 32'(win_idx), 0);
    // R9: none true
    drive(4'b0000, 4'hF, 1, 1);
    check("R9 none", 32'(none_hit), 1);
    check("R9 win", 32'(win_idx), 0);

    // R4: timer must be 1; R5: counter must be 0
    wr(2, 25'h30000);
    wr(3, 25'h200000);
    drive(4'h0, 4'h0, 1, 1);
    check("R4 tmr hi", 32'(cond_hit), 32'b0100);
    check("R4 win", 32'(win_idx), 2);
    drive(4'h0, 4'h0, 0, 0);
    check("R5 cnt lo", 32'(cond_hit), 32'b1000);
    check("R5 win", 32'(win_idx), 3);

    // R3: OR term of group 2 required low; R6 level without include ignored
    wr(0, 25'h800 | 25'h5);
    drive(4'h0, 4'b0000, 0, 1);
    check("R3 or lo", 32'(cond_hit[0]), 1);
    drive(4'h0, 4'b0100, 0, 1);
    check("R3 or hi", 32'(cond_hit[0]), 0);

    // R6: two terms both needed
    wr(1, 25'h30000 | 25'h3);
    drive(4'b0001, 4'h0, 0, 1);
    check("R6 one of two", 32'(cond_hit[1]), 0);
    drive(4'b0001, 4'h0, 1, 1);
    check("R6 both", 32'(cond_hit[1]), 1);

    // R7: empty false, inverted empty true
    wr(2, 25'h115555);
    drive(4'hF, 4'hF, 1, 1);
    check("R7 empty", 32'(cond_hit[2]), 0);
    wr(2, 25'h1000000);
    check("R7 invert", 32'(cond_hit[2]), 1);
    wr(2, 25'h1000003);
    check("R7 invert match", 32'(cond_hit[2]), 0);

    // R10: out-of-range write ignored, outputs unchanged
    wr(0, 25'h0);
    wr(1, 25'h0);
    wr(3, 25'h0);
    wr(2, 25'h0);
    wr(NC, 25'h1000000);
    wr((1 << IW) - 1, 25'h1000000);
    check("R10 oob", 32'(cond_hit), 0);
    check("R10 oob none", 32'(none_hit), 1);
    wr(3, 25'h1000000);
    check("R10 load", 32'(cond_hit), 32'b1000);

    // Random mix, R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 2) == 0)
        wr(int'($urandom_range(0, (1 << IW) - 1)), 25'($urandom & $urandom & $urandom));
      drive(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
      check_model("R6 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule